// File: doc/BRIEF.md
# Adaptive Receive Equalizer Sequencer

This controller runs the adaptive receive-equalization search of a multi-lane high-speed link redriver. Two four-level strap inputs and a configuration bit decide whether adaptation is enabled. While fixed-rate link training is active, the controller waits for an allowed window. The window is the first transmitter FFE level while one of the designated training patterns arrives. In that window it sweeps equalizer codes upward and watches an over-equalization flag from a single reference lane. It then locks the highest code that keeps the flag low.

The locked code, or during the sweep the code under trial, is sent to every data lane. The data-lane and clock-lane output enables stay low until the search ends, unless a register bit clears that gating. When the link is in a legacy (non-training) mode, or adaptation is disabled, the lanes take a static code instead. That code is the two-bit strap value, or the register code when the mode strap selects register control. The analog equalizer, the comparator and the training engine sit outside and connect only through ports.

Top module: `aeq_seq_ctrl`

## Requirements
- R1: Strap levels are encoded 2'b00 = low, 2'b01 = R, 2'b10 = F, 2'b11 = high. With the mode strap at F, `cfg_aeq_en` alone enables adaptation. With the mode strap at R or high, adaptation is enabled only when the map strap is F or high, and `cfg_aeq_en` is ignored. With the mode strap low, adaptation is always disabled.
- R2: When adaptation is enabled and `frl_active` is high, a `lt_start` or `rate_change` pulse restarts the search from code 0 in any state, including after a lock. Probing advances only while `ffe_level` is 0 and `lt_pattern` is 5, 6, 7 or 8. Otherwise the search waits, and the code stays unchanged.
- R3: Each trial code is held for `dwell_cycles` cycles (0 acts as 1), and `ref_overeq` is sampled on the last cycle. The first code is 0 and each later trial adds one. The controller locks the highest code that did not raise the flag, or 0 when code 0 already raises it. When the top code passes, it locks the top code.
- R4: If `ffe_level` becomes nonzero during the search, the controller locks at once on the best code found so far. After that, the code holds regardless of `ref_overeq` or `ffe_level`.
- R5: If the search has not finished `timeout_cycles` cycles after it starts, it is forced to lock on the best code found so far. `aeq_done` rises exactly `timeout_cycles` cycles after the start edge.
- R6: `lane_eq` carries `eq_code` in every lane slice.
- R7: While adaptation is enabled and `frl_active` is high, `data_oe` and `clk_oe` stay low until `aeq_done` is high. With the mode strap at F, `cfg_gate_en` = 0 removes this gating. In every other case the enables are high.
- R8: When the controller is idle (legacy mode or adaptation disabled), `eq_code` is `cfg_eq_code` if the mode strap is F, and otherwise the zero-extended `strap_eq`.
- R9: A synchronous reset returns the controller to idle with `aeq_busy` and `aeq_done` low, so the outputs are gated if gating applies.
- R10: `aeq_busy` is high exactly while a search is in progress. `aeq_done` is high while a locked code is held. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_lvl | input | 2 | Mode strap level |
| map_lvl | input | 2 | Map-select strap level |
| cfg_aeq_en | input | 1 | Register enable for adaptation (mode F) |
| cfg_gate_en | input | 1 | Register enable for output gating (mode F) |
| cfg_eq_code | input | EQ_W | Register static equalizer code |
| strap_eq | input | 2 | Sampled strap equalizer code |
| dwell_cycles | input | DWELL_W | Settling cycles per trial code |
| timeout_cycles | input | TMO_W | Search time limit in cycles |
| frl_active | input | 1 | High during fixed-rate training/operation, low in legacy mode |
| lt_start | input | 1 | Link training start pulse |
| rate_change | input | 1 | Link rate change pulse |
| ffe_level | input | 2 | Current transmitter FFE level |
| lt_pattern | input | 4 | Training pattern ID being received |
| ref_overeq | input | 1 | Over-equalization flag from the reference lane |
| lane_eq | output | LANES*EQ_W | Equalizer code for each data lane |
| eq_code | output | EQ_W | Code currently applied |
| data_oe | output | LANES | Data-lane output enables |
| clk_oe | output | 1 | Clock-lane output enable |
| aeq_busy | output | 1 | Search in progress |
| aeq_done | output | 1 | Code locked |

## Verification
The bench builds the controller with EQ_W = 4, LANES = 4, DWELL_W = 4 and TMO_W = 10. With 16 codes, a full sweep up to the top code ends within about 50 cycles. The bench drives a dwell of 3 cycles and a default limit of 500 cycles, so the forced-timeout path can be hit exactly with a limit of 10. The comparator is modelled as a threshold on the applied code, which puts every lock point, including code 0 and the top code, within reach.

// File: rtl/aeq_pkg.sv
package aeq_pkg;

    localparam int PAT_W = 4;
    localparam int FFE_W = 2;

    typedef enum logic [1:0] {
        LVL_LO = 2'b00,
        LVL_R  = 2'b01,
        LVL_F  = 2'b10,
        LVL_HI = 2'b11
    } lvl4_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DWELL,
        ST_LOCK
    } seq_st_t;

    function automatic logic aeq_decode(lvl4_t mode, lvl4_t map, logic reg_en);
        logic en;
        case (mode)
            LVL_F:         en = reg_en;
            LVL_R, LVL_HI: en = (map == LVL_F) || (map == LVL_HI);
            default:       en = 1'b0;
        endcase
        return en;
    endfunction

    function automatic logic pattern_ok(logic [PAT_W-1:0] pat);
        return (pat >= PAT_W'(5)) && (pat <= PAT_W'(8));
    endfunction

endpackage

// File: rtl/aeq_mode_decode.sv
module aeq_mode_decode
    import aeq_pkg::*;
(
    input  logic [1:0] mode_lvl,
    input  logic [1:0] map_lvl,
    input  logic       cfg_aeq_en,
    input  logic       cfg_gate_en,
    output logic       aeq_en,
    output logic       gate_en,
    output logic       reg_ctrl
);
    lvl4_t mode_s;
    lvl4_t map_s;

    always_comb begin
        mode_s   = lvl4_t'(mode_lvl);
        map_s    = lvl4_t'(map_lvl);
        reg_ctrl = (mode_s == LVL_F);
        aeq_en   = aeq_decode(mode_s, map_s, cfg_aeq_en);
        gate_en  = reg_ctrl ? cfg_gate_en : 1'b1;
    end
endmodule

// File: rtl/aeq_search_fsm.sv
module aeq_search_fsm
    import aeq_pkg::*;
#(
    parameter int EQ_W    = 4,
    parameter int DWELL_W = 8,
    parameter int TMO_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               aeq_en,
    input  logic               frl_active,
    input  logic               lt_start,
    input  logic               rate_change,
    input  logic [FFE_W-1:0]   ffe_level,
    input  logic [PAT_W-1:0]   lt_pattern,
    input  logic               ref_overeq,
    input  logic [DWELL_W-1:0] dwell_cycles,
    input  logic [TMO_W-1:0]   timeout_cycles,
    output logic [EQ_W-1:0]    fsm_code,
    output logic               fsm_idle,
    output logic               busy,
    output logic               done
);
    localparam logic [EQ_W-1:0] CODE_MAX = {EQ_W{1'b1}};

    seq_st_t            st_q;
    logic [EQ_W-1:0]    probe_q;
    logic [EQ_W-1:0]    best_q;
    logic [DWELL_W-1:0] dcnt_q;
    logic [TMO_W-1:0]   tcnt_q;

    logic               active;
    logic               restart;
    logic               pat_ok;
    logic               ffe0;
    logic [DWELL_W:0]   dcnt_nx;
    logic [TMO_W:0]     tcnt_nx;
    logic               dwell_end;
    logic               tmo_hit;

    always_comb begin
        active    = aeq_en && frl_active;
        restart   = active && (lt_start || rate_change);
        pat_ok    = pattern_ok(lt_pattern);
        ffe0      = (ffe_level == '0);
        dcnt_nx   = {1'b0, dcnt_q} + 1'b1;
        tcnt_nx   = {1'b0, tcnt_q} + 1'b1;
        dwell_end = dcnt_nx >= {1'b0, dwell_cycles};
        tmo_hit   = tcnt_nx >= {1'b0, timeout_cycles};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            probe_q <= '0;
            best_q  <= '0;
            dcnt_q  <= '0;
            tcnt_q  <= '0;
        end else if (restart) begin
            st_q    <= ST_WAIT;
            probe_q <= '0;
            best_q  <= '0;
            dcnt_q  <= '0;
            tcnt_q  <= '0;
        end else if (!active) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (tmo_hit) begin
                        st_q <= ST_LOCK;
                    end else begin
                        tcnt_q <= tcnt_nx[TMO_W-1:0];
                        if (ffe0 && pat_ok) begin
                            st_q   <= ST_DWELL;
                            dcnt_q <= '0;
                        end
                    end
                end
                ST_DWELL: begin
                    if (tmo_hit || !ffe0) begin
                        st_q <= ST_LOCK;
                    end else begin
                        tcnt_q <= tcnt_nx[TMO_W-1:0];
                        if (pat_ok) begin
                            if (dwell_end) begin
                                if (ref_overeq) begin
                                    st_q <= ST_LOCK;
                                end else begin
                                    best_q <= probe_q;
                                    if (probe_q == CODE_MAX) begin
                                        st_q <= ST_LOCK;
                                    end else begin
                                        probe_q <= probe_q + 1'b1;
                                        dcnt_q  <= '0;
                                    end
                                end
                            end else begin
                                dcnt_q <= dcnt_nx[DWELL_W-1:0];
                            end
                        end
                    end
                end
                default: st_q <= st_q;
            endcase
        end
    end

    always_comb begin
        fsm_idle = (st_q == ST_IDLE);
        busy     = (st_q == ST_WAIT) || (st_q == ST_DWELL);
        done     = (st_q == ST_LOCK);
        fsm_code = done ? best_q : probe_q;
    end
endmodule

// File: rtl/aeq_lane_out.sv
module aeq_lane_out #(
    parameter int EQ_W  = 4,
    parameter int LANES = 4
) (
    input  logic                  aeq_en,
    input  logic                  frl_active,
    input  logic                  gate_en,
    input  logic                  done,
    input  logic                  fsm_idle,
    input  logic [EQ_W-1:0]       fsm_code,
    input  logic [EQ_W-1:0]       static_code,
    output logic [LANES*EQ_W-1:0] lane_eq,
    output logic [EQ_W-1:0]       eq_code,
    output logic [LANES-1:0]      data_oe,
    output logic                  clk_oe
);
    logic gated;
    logic oe_on;

    always_comb begin
        eq_code = fsm_idle ? static_code : fsm_code;
        gated   = aeq_en && frl_active && gate_en;
        oe_on   = !gated || done;
        clk_oe  = oe_on;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g*EQ_W +: EQ_W] = eq_code;
        assign data_oe[g]              = oe_on;
    end
endmodule

// File: rtl/aeq_seq_ctrl.sv
module aeq_seq_ctrl
    import aeq_pkg::*;
#(
    parameter int EQ_W    = 4,
    parameter int LANES   = 4,
    parameter int DWELL_W = 8,
    parameter int TMO_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            mode_lvl,
    input  logic [1:0]            map_lvl,
    input  logic                  cfg_aeq_en,
    input  logic                  cfg_gate_en,
    input  logic [EQ_W-1:0]       cfg_eq_code,
    input  logic [1:0]            strap_eq,
    input  logic [DWELL_W-1:0]    dwell_cycles,
    input  logic [TMO_W-1:0]      timeout_cycles,
    input  logic                  frl_active,
    input  logic                  lt_start,
    input  logic                  rate_change,
    input  logic [1:0]            ffe_level,
    input  logic [3:0]            lt_pattern,
    input  logic                  ref_overeq,
    output logic [LANES*EQ_W-1:0] lane_eq,
    output logic [EQ_W-1:0]       eq_code,
    output logic [LANES-1:0]      data_oe,
    output logic                  clk_oe,
    output logic                  aeq_busy,
    output logic                  aeq_done
);
    logic            aeq_en;
    logic            gate_en;
    logic            reg_ctrl;
    logic            fsm_idle;
    logic [EQ_W-1:0] fsm_code;
    logic [EQ_W-1:0] static_code;

    aeq_mode_decode u_dec (
        .mode_lvl   (mode_lvl),
        .map_lvl    (map_lvl),
        .cfg_aeq_en (cfg_aeq_en),
        .cfg_gate_en(cfg_gate_en),
        .aeq_en     (aeq_en),
        .gate_en    (gate_en),
        .reg_ctrl   (reg_ctrl)
    );

    assign static_code = reg_ctrl ? cfg_eq_code : EQ_W'(strap_eq);

    aeq_search_fsm #(
        .EQ_W   (EQ_W),
        .DWELL_W(DWELL_W),
        .TMO_W  (TMO_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .aeq_en        (aeq_en),
        .frl_active    (frl_active),
        .lt_start      (lt_start),
        .rate_change   (rate_change),
        .ffe_level     (ffe_level),
        .lt_pattern    (lt_pattern),
        .ref_overeq    (ref_overeq),
        .dwell_cycles  (dwell_cycles),
        .timeout_cycles(timeout_cycles),
        .fsm_code      (fsm_code),
        .fsm_idle      (fsm_idle),
        .busy          (aeq_busy),
        .done          (aeq_done)
    );

    aeq_lane_out #(
        .EQ_W (EQ_W),
        .LANES(LANES)
    ) u_out (
        .aeq_en     (aeq_en),
        .frl_active (frl_active),
        .gate_en    (gate_en),
        .done       (aeq_done),
        .fsm_idle   (fsm_idle),
        .fsm_code   (fsm_code),
        .static_code(static_code),
        .lane_eq    (lane_eq),
        .eq_code    (eq_code),
        .data_oe    (data_oe),
        .clk_oe     (clk_oe)
    );
endmodule

// File: rtl/aeq_seq_ctrl_chk.sv
module aeq_seq_ctrl_chk #(
    parameter int EQ_W  = 4,
    parameter int LANES = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  lt_start,
    input logic                  rate_change,
    input logic [LANES*EQ_W-1:0] lane_eq,
    input logic [EQ_W-1:0]       eq_code,
    input logic [LANES-1:0]      data_oe,
    input logic                  clk_oe,
    input logic                  aeq_busy,
    input logic                  aeq_done
);
    // R6
    lane_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        lane_eq == {LANES{eq_code}});

    // R7
    oe_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        aeq_done |-> (data_oe == {LANES{1'b1}}) && clk_oe);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(aeq_busy && aeq_done));

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (aeq_done && $past(aeq_done)) |-> $stable(eq_code));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (aeq_busy && $past(aeq_busy) && !$past(lt_start) && !$past(rate_change))
        |-> (eq_code == $past(eq_code)) || (eq_code == EQ_W'($past(eq_code) + 1'b1)));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!aeq_busy && !aeq_done));
endmodule

bind aeq_seq_ctrl aeq_seq_ctrl_chk #(
    .EQ_W (EQ_W),
    .LANES(LANES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lt_start   (lt_start),
    .rate_change(rate_change),
    .lane_eq    (lane_eq),
    .eq_code    (eq_code),
    .data_oe    (data_oe),
    .clk_oe     (clk_oe),
    .aeq_busy   (aeq_busy),
    .aeq_done   (aeq_done)
);

// File: tb/test_aeq_seq_ctrl.sv
`timescale 1ns/1ps
module test_aeq_seq_ctrl;
    localparam int EQ_W    = 4;
    localparam int LANES   = 4;
    localparam int DWELL_W = 4;
    localparam int TMO_W   = 10;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0]            mode_lvl = 2'b01;
    logic [1:0]            map_lvl = 2'b10;
    logic                  cfg_aeq_en = 1'b0;
    logic                  cfg_gate_en = 1'b1;
    logic [EQ_W-1:0]       cfg_eq_code = '0;
    logic [1:0]            strap_eq = 2'b00;
    logic [DWELL_W-1:0]    dwell_cycles = 4'd3;
    logic [TMO_W-1:0]      timeout_cycles = 10'd500;
    logic                  frl_active = 1'b1;
    logic                  lt_start = 1'b0;
    logic                  rate_change = 1'b0;
    logic [1:0]            ffe_level = 2'd0;
    logic [3:0]            lt_pattern = 4'd0;
    logic                  ref_overeq;
    logic [LANES*EQ_W-1:0] lane_eq;
    logic [EQ_W-1:0]       eq_code;
    logic [LANES-1:0]      data_oe;
    logic                  clk_oe;
    logic                  aeq_busy;
    logic                  aeq_done;

    int  thr = 15;
    bit  all_flag = 1'b0;
    int  checks = 0;
    int  failures = 0;
    int  cyc = 0;
    bit  reported = 1'b0;

    assign ref_overeq = all_flag || (int'(eq_code) > thr);

    always #10 clk = ~clk;

    aeq_seq_ctrl #(
        .EQ_W(EQ_W), .LANES(LANES), .DWELL_W(DWELL_W), .TMO_W(TMO_W)
    ) i_aeq_seq_ctrl (
        .clk(clk), .rst(rst), .mode_lvl(mode_lvl), .map_lvl(map_lvl),
        .cfg_aeq_en(cfg_aeq_en), .cfg_gate_en(cfg_gate_en),
        .cfg_eq_code(cfg_eq_code), .strap_eq(strap_eq),
        .dwell_cycles(dwell_cycles), .timeout_cycles(timeout_cycles),
        .frl_active(frl_active), .lt_start(lt_start),
        .rate_change(rate_change), .ffe_level(ffe_level),
        .lt_pattern(lt_pattern), .ref_overeq(ref_overeq),
        .lane_eq(lane_eq), .eq_code(eq_code), .data_oe(data_oe),
        .clk_oe(clk_oe), .aeq_busy(aeq_busy), .aeq_done(aeq_done)
    );

    // {mode, map, cfg_aeq_en, expected enable}
    localparam logic [5:0] VEC [18] = '{
        6'b00_00_1_0, 6'b00_01_1_0, 6'b00_10_1_0, 6'b00_11_1_0,
        6'b01_00_0_0, 6'b01_01_0_0, 6'b01_10_0_1, 6'b01_11_0_1,
        6'b10_00_1_1, 6'b10_01_1_1, 6'b10_10_1_1, 6'b10_11_1_1,
        6'b10_00_0_0, 6'b10_11_0_0,
        6'b11_00_0_0, 6'b11_01_0_0, 6'b11_10_0_1, 6'b11_11_0_1
    };

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        lt_start = 1'b1;
        @(negedge clk);
        lt_start = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !aeq_done; i++) @(negedge clk);
    endtask

    function automatic bit lanes_all(input int code);
        for (int i = 0; i < LANES; i++)
            if (int'(lane_eq[i*EQ_W +: EQ_W]) != code) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    initial begin
        // R9: reset state, gated outputs with adaptation enabled
        do_reset();
        @(negedge clk);
        chk(!aeq_busy && !aeq_done, "R9 flags after reset", {aeq_busy, aeq_done}, 0);
        chk(data_oe == '0 && !clk_oe, "R9 gated after reset", {data_oe, clk_oe}, 0);

        // R1: enable decode table
        foreach (VEC[k]) begin
            mode_lvl   = VEC[k][5:4];
            map_lvl    = VEC[k][3:2];
            cfg_aeq_en = VEC[k][1];
            cfg_gate_en = 1'b1;
            lt_pattern = 4'd0;
            do_reset();
            pulse_start();
            chk(aeq_busy == VEC[k][0], "R1 decode busy", aeq_busy, VEC[k][0]);
            chk(data_oe == (VEC[k][0] ? 4'h0 : 4'hF), "R1 decode gating",
                data_oe, VEC[k][0] ? 0 : 15);
        end

        // R2/R3: wait outside window, then search locks on threshold
        mode_lvl = 2'b01; map_lvl = 2'b10; cfg_aeq_en = 1'b0;
        thr = 5; lt_pattern = 4'd2;
        do_reset();
        pulse_start();
        repeat (20) @(negedge clk);
        chk(aeq_busy && eq_code == 0, "R2 no probing outside pattern window", eq_code, 0);
        chk(data_oe == 4'h0 && !clk_oe, "R7 gated while busy", data_oe, 0);
        lt_pattern = 4'd6;
        wait_done(300);
        chk(aeq_done && eq_code == 5, "R3 lock at threshold", eq_code, 5);
        chk(lanes_all(5), "R6 broadcast", lane_eq, 5);
        chk(data_oe == 4'hF && clk_oe, "R7 enabled after done", data_oe, 15);
        chk(!aeq_busy, "R10 busy low when done", aeq_busy, 0);

        // R2: rate change during hold re-runs
        thr = 3;
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
        chk(aeq_busy && !aeq_done, "R2 rerun on rate change", aeq_done, 0);
        chk(data_oe == 4'h0, "R7 regated on rate change", data_oe, 0);
        wait_done(300);
        chk(aeq_done && eq_code == 3, "R2 relock after rate change", eq_code, 3);

        // R3: every code over-equalized -> 0
        all_flag = 1'b1;
        pulse_start();
        wait_done(300);
        chk(aeq_done && eq_code == 0, "R3 all flagged lock zero", eq_code, 0);
        all_flag = 1'b0;

        // R3: no code flagged -> top code
        thr = 99;
        pulse_start();
        wait_done(300);
        chk(aeq_done && eq_code == 15, "R3 top code lock", eq_code, 15);

        // R4: FFE level change freezes best so far
        thr = 99;
        pulse_start();
        for (int i = 0; i < 300 && eq_code != 3; i++) @(negedge clk);
        ffe_level = 2'd1;
        @(negedge clk);
        chk(aeq_done && eq_code == 2, "R4 freeze on FFE change", eq_code, 2);
        thr = 0;
        ffe_level = 2'd2;
        repeat (10) @(negedge clk);
        chk(aeq_done && eq_code == 2, "R4 code held", eq_code, 2);
        ffe_level = 2'd0;

        // R5: timeout with no allowed pattern
        lt_pattern = 4'd2;
        timeout_cycles = 10'd10;
        pulse_start();
        repeat (9) @(negedge clk);
        chk(!aeq_done, "R5 not done before limit", aeq_done, 0);
        @(negedge clk);
        chk(aeq_done && eq_code == 0, "R5 forced lock at limit", eq_code, 0);
        timeout_cycles = 10'd500;
        lt_pattern = 4'd6;

        // R7: gating bypass in register mode
        mode_lvl = 2'b10; cfg_aeq_en = 1'b1; cfg_gate_en = 1'b0;
        pulse_start();
        chk(aeq_busy && data_oe == 4'hF && clk_oe, "R7 gating cleared", data_oe, 15);
        cfg_gate_en = 1'b1;

        // R8: legacy mode static codes
        frl_active = 1'b0;
        mode_lvl = 2'b01; strap_eq = 2'b10;
        repeat (2) @(negedge clk);
        chk(eq_code == 2 && lanes_all(2), "R8 strap code", eq_code, 2);
        chk(data_oe == 4'hF && clk_oe, "R7 legacy enables", data_oe, 15);
        chk(!aeq_busy && !aeq_done, "R10 idle flags", {aeq_busy, aeq_done}, 0);
        mode_lvl = 2'b10; cfg_eq_code = 4'd9;
        @(negedge clk);
        chk(eq_code == 9, "R8 register code", eq_code, 9);

        report();
    end
endmodule